// File: doc/BRIEF.md
# Prescaled Down-Counter Timer Channel

This block is a single channel of a timer peripheral. A down-counter steps once every N pulses of a timer-clock enable. N is 1, 16 or 256, set by a prescale field. The channel runs in one of three ways: it can reload from a stored limit (periodic), wrap to all-ones (free-running), or stop at zero (one-shot). The count is either 16 or 32 bits wide, and the width can be changed while the channel runs. In 16-bit width the upper half of the value is kept and is not touched.

The bus decoder in front of the block drives a set of one-cycle strobes that share one write-data bus:
- a count load, which sets both the limit and the count;
- a background load, which sets the limit only;
- a control write;
- an interrupt clear.

The block returns the current count, the limit, the control word, a raw expiry flag and that flag masked by its enable bit. Everything runs on one clock, and the timer rate arrives as a tick enable.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control word reads 0x20, the limit reads 0, the count reads 0xFFFFFFFF, and both interrupt outputs are low.
- R2: The control word has these fields:
  - bit 0: stop after first expiry;
  - bit 1: width (1 = 32-bit, 0 = 16-bit);
  - bits 3:2: prescale code;
  - bit 5: interrupt enable;
  - bit 6: mode (1 = periodic, 0 = free-running);
  - bit 7: run enable.
  Every other bit reads back as zero, whatever was written.
- R3: A count-load write sets both the limit and the count to the written data. A background-load write sets only the limit and leaves the count as it was.
- R4: Prescale code 00 steps on every tick, 01 on every 16th tick, and 10 and 11 on every 256th tick. The tick phase starts again from zero whenever the prescale code changes or the counter is not running.
- R5: A step taken while the in-width count is zero does one of two things. In periodic mode it reloads the limit; in 16-bit width only the low half is reloaded. In free-running mode it wraps the in-width part to all ones.
- R6: The raw flag sets on a step from an in-width count of one to zero. An interrupt-clear strobe clears it. The masked output equals the raw flag AND control bit 5.
- R7: In 16-bit width only the low 16 bits decrement or wrap, and the upper 16 bits keep their value. Changing the width keeps the count as it is.
- R8: With bit 0 set, the counter stops at zero after the first expiry. A later control write with bit 7 set lets it step again, starting from that zero.
- R9: In periodic mode, a count load whose in-width value is zero stops the counter. A later non-zero count load starts it again.
- R10: While bit 7 is clear the count holds its value on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer-clock enable, one pulse per timer tick |
| load_wr | input | 1 | Count-load strobe (limit and count) |
| bgload_wr | input | 1 | Background-load strobe (limit only) |
| ctrl_wr | input | 1 | Control-word write strobe |
| int_clr | input | 1 | Raw interrupt clear strobe |
| wdata | input | CNT_W | Write data shared by all strobes |
| value_o | output | CNT_W | Current count |
| load_o | output | CNT_W | Stored limit |
| ctrl_o | output | CNT_W | Control word, unused bits zero |
| raw_irq | output | 1 | Raw expiry flag |
| masked_irq | output | 1 | Expiry flag gated by the interrupt enable |

## Verification
The assertions assume the decoder raises at most one write strobe in any cycle. They also assume that a width change or a count load never falls in the same cycle as an expiry step, because either one would change the in-width zero test under the raw flag. The bench keeps to both assumptions: each strobe lasts one cycle and is driven with the tick enable held low, so register writes and counting never overlap. The bench sweeps every prescale code and every combination of mode and width. It takes its expected counts from the number of ticks it has applied divided by the prescale ratio.

// File: rtl/tmr_pkg.sv
// Shared constants and the decoded control type for the timer channel.
// Assumes a control word of eight bits; bit positions are fixed because
// software and the channel logic both decode them.
package tmr_pkg;

    localparam int CTRL_W     = 8;
    localparam int ONESHOT_BIT = 0;
    localparam int WIDE_BIT    = 1;
    localparam int PRE_LO_BIT  = 2;
    localparam int IRQEN_BIT   = 5;
    localparam int MODE_BIT    = 6;
    localparam int EN_BIT      = 7;

    localparam logic [CTRL_W-1:0] CTRL_RST  = 8'h20;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hEF;

    typedef struct packed {
        logic       enable;
        logic       periodic;
        logic       irq_en;
        logic [1:0] prescale;
        logic       wide;
        logic       oneshot;
    } tmr_cfg_t;

endpackage

// File: rtl/tmr_ctrl_reg.sv
// Control register of the timer channel.
// Holds the masked control word, decodes it into fields and flags a write
// that changes the prescale code. Assumes one-cycle write strobes.
module tmr_ctrl_reg
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] wdata,
    output tmr_cfg_t          cfg,
    output logic [CNT_W-1:0]  ctrl_word,
    output logic              pre_chg
);

    logic [CTRL_W-1:0] ctrl_q;

    // Store the written control word with reserved bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (ctrl_wr) begin
            ctrl_q <= wdata & CTRL_MASK;
        end
    end

    // Split the stored word into named fields.
    always_comb begin
        cfg.enable   = ctrl_q[EN_BIT];
        cfg.periodic = ctrl_q[MODE_BIT];
        cfg.irq_en   = ctrl_q[IRQEN_BIT];
        cfg.prescale = ctrl_q[PRE_LO_BIT +: 2];
        cfg.wide     = ctrl_q[WIDE_BIT];
        cfg.oneshot  = ctrl_q[ONESHOT_BIT];
    end

    assign ctrl_word = CNT_W'(ctrl_q);
    assign pre_chg   = ctrl_wr && (wdata[PRE_LO_BIT +: 2] != ctrl_q[PRE_LO_BIT +: 2]);

    // R2: a write leaves no reserved bit set in the stored word
    a_r2_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_q[4] == 1'b0));

endmodule

// File: rtl/tmr_prescale.sv
// Tick prescaler of the timer channel.
// Counts tick enables and emits one step per 1, 2**MID_LOG2 or 2**HI_LOG2
// ticks. The phase restarts while the counter is not running or when the
// prescale code changes.
module tmr_prescale #(
    parameter int MID_LOG2 = 4,
    parameter int HI_LOG2  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       active,
    input  logic       restart,
    input  logic [1:0] code,
    output logic       step
);

    localparam logic [HI_LOG2-1:0] MID_TERM = HI_LOG2'((1 << MID_LOG2) - 1);

    logic [HI_LOG2-1:0] pre_q;
    logic [HI_LOG2-1:0] term;

    // Pick the terminal phase for the selected ratio.
    always_comb begin
        case (code)
            2'b00:   term = '0;
            2'b01:   term = MID_TERM;
            default: term = '1;
        endcase
    end

    assign step = active && tick_en && (pre_q == term);

    // Advance the phase on each tick and wrap after a step.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active) begin
            pre_q <= '0;
        end else if (tick_en) begin
            pre_q <= step ? '0 : pre_q + HI_LOG2'(1);
        end
    end

    // R4: a step only happens on a tick of a running counter
    a_r4_step_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (tick_en && active));

endmodule

// File: rtl/tmr_count_core.sv
// Count, limit and expiry logic of the timer channel.
// Applies load writes and prescaled steps, handles reload, wrap, the
// one-shot stop and the raw expiry flag. Assumes at most one write strobe
// per cycle.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load_wr,
    input  logic             bgload_wr,
    input  logic             ctrl_wr,
    input  logic             int_clr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             en,
    input  logic             periodic,
    input  logic             wide,
    input  logic             oneshot,
    output logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] load_val,
    output logic             raw_irq,
    output logic             active
);

    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  cnt_step;
    logic [HALF_W-1:0] lo;
    logic [HALF_W-1:0] hi;
    logic              halted_q;
    logic              raw_q;
    logic              at_zero;
    logic              at_one;
    logic              hit_zero;
    logic              wr_zero;

    assign lo = cnt_q[HALF_W-1:0];
    assign hi = cnt_q[CNT_W-1:HALF_W];

    // Work out the count after one step in the current width and mode.
    always_comb begin
        at_zero = (lo == '0) && (!wide || hi == '0);
        at_one  = (lo == HALF_W'(1)) && (!wide || hi == '0);
        if (at_zero) begin
            if (periodic) begin
                cnt_step = wide ? load_q : {hi, load_q[HALF_W-1:0]};
            end else begin
                cnt_step = wide ? '1 : {hi, {HALF_W{1'b1}}};
            end
        end else begin
            cnt_step = wide ? cnt_q - CNT_W'(1) : {hi, lo - HALF_W'(1)};
        end
        hit_zero = step && at_one;
        wr_zero  = wide ? (wdata == '0) : (wdata[HALF_W-1:0] == '0);
    end

    // Update count, limit and stop state from writes and steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '1;
            load_q   <= '0;
            halted_q <= 1'b0;
        end else begin
            if (load_wr) begin
                cnt_q  <= wdata;
                load_q <= wdata;
                if (periodic) begin
                    halted_q <= wr_zero;
                end
            end else begin
                if (bgload_wr) begin
                    load_q <= wdata;
                end
                if (step) begin
                    cnt_q <= cnt_step;
                end
                if (hit_zero && oneshot) begin
                    halted_q <= 1'b1;
                end
            end
            if (ctrl_wr && wdata[EN_BIT]) begin
                halted_q <= 1'b0;
            end
        end
    end

    // Raise the expiry flag on reaching zero; clear it on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (hit_zero) begin
            raw_q <= 1'b1;
        end else if (int_clr) begin
            raw_q <= 1'b0;
        end
    end

    assign value    = cnt_q;
    assign load_val = load_q;
    assign raw_irq  = raw_q;
    assign active   = en && !halted_q;

    // R3: a count load copies the data into both count and limit
    a_r3_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (cnt_q == $past(wdata)) && (load_q == $past(wdata)));

    // R3: a background load without a step leaves the count alone
    a_r3_bg_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (bgload_wr && !step) |=> ($stable(cnt_q) && load_q == $past(wdata)));

    // R10: a disabled channel holds its count unless loaded
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load_wr) |=> $stable(cnt_q));

    // R8: an expired one-shot channel does not move
    a_r8_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && !load_wr) |=> $stable(cnt_q));

    // R6: the flag only rises with the in-width count at zero
    a_r6_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(raw_q) && !$past(load_wr) && !$past(ctrl_wr)) |-> at_zero);

    // R6: a clear without a concurrent step drops the flag
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !step) |=> !raw_q);

endmodule

// File: rtl/tmr_chan.sv
// Top of one programmable timer channel.
// Joins the control register, the tick prescaler and the count core, and
// forms the masked interrupt. Assumes one clock with a tick enable and a
// decoder that raises one write strobe per cycle.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int MID_LOG2 = 4,
    parameter int HI_LOG2  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_wr,
    input  logic             bgload_wr,
    input  logic             ctrl_wr,
    input  logic             int_clr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] ctrl_o,
    output logic             raw_irq,
    output logic             masked_irq
);

    tmr_cfg_t cfg;
    logic     pre_chg;
    logic     step;
    logic     active;

    tmr_ctrl_reg #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wdata     (wdata[CTRL_W-1:0]),
        .cfg       (cfg),
        .ctrl_word (ctrl_o),
        .pre_chg   (pre_chg)
    );

    tmr_prescale #(
        .MID_LOG2 (MID_LOG2),
        .HI_LOG2  (HI_LOG2)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .active  (active),
        .restart (pre_chg),
        .code    (cfg.prescale),
        .step    (step)
    );

    tmr_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .load_wr   (load_wr),
        .bgload_wr (bgload_wr),
        .ctrl_wr   (ctrl_wr),
        .int_clr   (int_clr),
        .wdata     (wdata),
        .en        (cfg.enable),
        .periodic  (cfg.periodic),
        .wide      (cfg.wide),
        .oneshot   (cfg.oneshot),
        .value     (value_o),
        .load_val  (load_o),
        .raw_irq   (raw_irq),
        .active    (active)
    );

    assign masked_irq = raw_irq && cfg.irq_en;

    // R6: the masked output never shows without the raw flag
    a_r6_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
        masked_irq |-> raw_irq);

endmodule

// File: tb/tmr_chan_bench.sv
// Self-checking bench for tmr_chan: strobes are driven on the falling edge,
// one at a time with tick_en low, and outputs are sampled on falling edges.
module tmr_chan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        load_wr = 1'b0;
    logic        bgload_wr = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic        int_clr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] value_o;
    logic [31:0] load_o;
    logic [31:0] ctrl_o;
    logic        raw_irq;
    logic        masked_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tmr_chan u_tmr_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .load_wr    (load_wr),
        .bgload_wr  (bgload_wr),
        .ctrl_wr    (ctrl_wr),
        .int_clr    (int_clr),
        .wdata      (wdata),
        .value_o    (value_o),
        .load_o     (load_o),
        .ctrl_o     (ctrl_o),
        .raw_irq    (raw_irq),
        .masked_irq (masked_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk); ctrl_wr = 1'b1; wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr_load(input logic [31:0] v);
        @(negedge clk); load_wr = 1'b1; wdata = v;
        @(negedge clk); load_wr = 1'b0;
    endtask

    task automatic wr_bg(input logic [31:0] v);
        @(negedge clk); bgload_wr = 1'b1; wdata = v;
        @(negedge clk); bgload_wr = 1'b0;
    endtask

    task automatic clr_irq();
        @(negedge clk); int_clr = 1'b1;
        @(negedge clk); int_clr = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctrl", ctrl_o, 32'h20);
        chk("R1 load", load_o, 32'h0);
        chk("R1 value", value_o, 32'hFFFF_FFFF);
        chk("R1 irq", {30'd0, raw_irq, masked_irq}, 32'h0);

        // R2 reserved bits read zero
        wr_ctrl(32'hFFFF_FFFF);
        chk("R2 mask", ctrl_o, 32'hEF);
        wr_ctrl(32'h0000_0062);
        chk("R2 writeback", ctrl_o, 32'h62);

        // R3 count load and background load
        wr_load(32'h1234_5678);
        chk("R3 load value", value_o, 32'h1234_5678);
        chk("R3 load limit", load_o, 32'h1234_5678);
        wr_bg(32'h0000_0055);
        chk("R3 bg limit", load_o, 32'h55);
        chk("R3 bg keeps count", value_o, 32'h1234_5678);

        // R4 sweep of all prescale codes, 32-bit periodic
        for (int code = 0; code < 4; code++) begin
            int div;
            div = (code == 0) ? 1 : (code == 1) ? 16 : 256;
            wr_ctrl(32'h62 | (code << 2));
            wr_load(32'd1000);
            wr_ctrl(32'hE2 | (code << 2));
            run(div * 3 - 1);
            chk("R4 before third step", value_o, 32'd998);
            run(1);
            chk("R4 third step", value_o, 32'd997);
        end

        // R4 prescale change restarts the phase
        wr_ctrl(32'h62);
        wr_load(32'd500);
        wr_ctrl(32'hE6);
        run(10);
        chk("R4 no step yet", value_o, 32'd500);
        wr_ctrl(32'hEE);
        run(255);
        chk("R4 phase restarted", value_o, 32'd500);
        run(1);
        chk("R4 step at 256", value_o, 32'd499);

        // R5 R6 periodic expiry and reload, 32-bit
        wr_ctrl(32'h62);
        clr_irq();
        wr_load(32'd3);
        wr_ctrl(32'hE2);
        run(3);
        chk("R6 count at zero", value_o, 32'd0);
        chk("R6 raw set", {31'd0, raw_irq}, 32'd1);
        chk("R6 masked set", {31'd0, masked_irq}, 32'd1);
        run(1);
        chk("R5 periodic reload", value_o, 32'd3);
        wr_ctrl(32'hC2);
        chk("R6 masked off", {31'd0, masked_irq}, 32'd0);
        chk("R6 raw kept", {31'd0, raw_irq}, 32'd1);
        clr_irq();
        chk("R6 clear", {31'd0, raw_irq}, 32'd0);

        // R5 free-running wrap, 32-bit
        wr_ctrl(32'h22);
        wr_load(32'd1);
        wr_ctrl(32'hA2);
        run(1);
        chk("R5 free zero", value_o, 32'd0);
        chk("R6 free raw", {31'd0, raw_irq}, 32'd1);
        run(1);
        chk("R5 free wrap 32", value_o, 32'hFFFF_FFFF);
        chk("R5 limit unused", load_o, 32'd1);
        clr_irq();

        // R7 R5 16-bit free-running keeps the upper half
        wr_ctrl(32'h20);
        wr_load(32'hABCD_0002);
        wr_ctrl(32'hA0);
        run(2);
        chk("R7 low half zero", value_o, 32'hABCD_0000);
        run(1);
        chk("R7 wrap 16", value_o, 32'hABCD_FFFF);

        // R7 width switch keeps the count
        wr_ctrl(32'h22);
        wr_load(32'h0001_0000);
        wr_ctrl(32'hA0);
        chk("R7 switch keeps", value_o, 32'h0001_0000);
        run(1);
        chk("R7 16-bit wrap after switch", value_o, 32'h0001_FFFF);

        // R7 R5 16-bit periodic reload with a background load
        wr_ctrl(32'h60);
        wr_load(32'h1234_0002);
        wr_ctrl(32'hE0);
        run(2);
        chk("R7 periodic zero", value_o, 32'h1234_0000);
        wr_bg(32'h9999_0005);
        chk("R3 bg during run", value_o, 32'h1234_0000);
        run(1);
        chk("R5 16-bit reload", value_o, 32'h1234_0005);
        clr_irq();

        // R8 one-shot stop and restart
        wr_ctrl(32'h62);
        wr_load(32'd2);
        wr_ctrl(32'hE3);
        run(2);
        chk("R8 expired", value_o, 32'd0);
        run(5);
        chk("R8 stays stopped", value_o, 32'd0);
        chk("R8 raw", {31'd0, raw_irq}, 32'd1);
        wr_ctrl(32'hE3);
        run(1);
        chk("R8 restart reloads", value_o, 32'd2);
        clr_irq();

        // R9 zero load stops periodic counting, non-zero restarts
        wr_ctrl(32'hE2);
        wr_load(32'd0);
        run(10);
        chk("R9 stopped", value_o, 32'd0);
        chk("R9 no irq", {31'd0, raw_irq}, 32'd0);
        wr_load(32'd4);
        run(1);
        chk("R9 restarted", value_o, 32'd3);

        // R10 disabled counter holds
        wr_ctrl(32'h62);
        run(20);
        chk("R10 hold", value_o, 32'd3);

        finish_run();
    end

endmodule